// File: doc/BRIEF.md
# Page Map Translator with Referenced/Dirty Upkeep

This block turns a 24-bit virtual address into a real address by looking it up in an external page map memory. The virtual address is an 8-bit high byte plus a 16-bit low word. The map index is the high byte joined with the upper byte of the low word. The map entry supplies the real page, and the word-in-page offset passes through unchanged. Every lookup reads the entry's two-bit access code and its flag bits. The block then either reports a fault or completes the translation. If the flags are stale, it first writes them back and reads the entry again.

A command selects one of two accesses: a read (source) access or a write (destination) access. It may also request a page step. A page step moves the stored current address one 256-word page forward or back before the lookup, and a carry or borrow ripples into the high byte. One command is in flight at a time. The caller waits for the one-cycle result pulse. `busy` tells it when a new command may be issued.

Top module: `page_xlate`

## Requirements
- R1: Every map read and write uses index `{va_hi, va_lo[15:8]}` of the current virtual address on `map_addr`.
- R2: A result with no fault carries `res_fault` = 0 and `res_addr` = `{entry[15:8], va_lo[7:0]}`. A faulted result carries `res_fault` = 1 (write-protect) or 2 (page fault), with `res_addr` = 0.
- R3: In a source access (`cmd_mode` = 0), an entry whose access code `entry[1:0]` is 3 gives a page fault and no write. Codes 0, 1 and 2 do not fault.
- R4: In a source access that does not fault, an entry with the referenced bit `entry[4]` clear is written back as `entry | 0x10`. An entry with that bit set is not written.
- R5: In a destination access (`cmd_mode` = 1), access code 2 gives a write-protect fault and code 3 gives a page fault, both with no write.
- R6: In a destination access with code 0 or 1, an entry with the dirty bit `entry[5]` clear is written back as `entry | 0xB0`. An entry with that bit set is not written.
- R7: A write-back is followed by a second read of the same index, and the result page comes from that second read.
- R8: With `cmd_adv` = 1 and `cmd_dir` = 0, the stored current address, not the command address, is stepped by adding 0x100 to the low word. A carry out increments the high byte.
- R9: With `cmd_adv` = 1 and `cmd_dir` = 1, 0x100 is subtracted from the stored low word. A borrow decrements the high byte.
- R10: After each accepted command, `cur_va_hi`/`cur_va_lo` hold the address that was translated: the command address, or the stepped one.
- R11: After reset, `busy`, `res_valid` and both map strobes are low. `busy` rises in the cycle after acceptance and stays high through the single `res_valid` cycle. `res_valid` comes 3 cycles after acceptance without a write-back and 6 cycles after with one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken while not busy |
| cmd_mode | input | 1 | 0 source (read) access, 1 destination (write) access |
| cmd_dir | input | 1 | Page step direction: 0 forward, 1 backward |
| cmd_adv | input | 1 | Step the stored address instead of loading the command address |
| cmd_va_hi | input | 8 | Virtual address high byte |
| cmd_va_lo | input | 16 | Virtual address low word |
| busy | output | 1 | A command is in progress |
| map_rd_en | output | 1 | Map read strobe; data is expected on the next cycle |
| map_wr_en | output | 1 | Map write strobe |
| map_addr | output | 16 | Map index |
| map_wdata | output | 16 | Entry written back |
| map_rdata | input | 16 | Entry read, one cycle after the read strobe |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 2 | 0 none, 1 write-protect, 2 page fault |
| res_addr | output | 16 | Real address |
| cur_va_hi | output | 8 | Stored current virtual high byte |
| cur_va_lo | output | 16 | Stored current virtual low word |

## Verification
The assertions assume that the map memory returns the entry one cycle after the read strobe and that the memory keeps what was written, so the second read sees the updated flags. They also assume that `cmd_valid` is never raised in the reset cycle. The bench models the map as a sparse memory with exactly that one-cycle read timing, and it drives commands only at falling edges and only after reset has been released. Indices the bench never fills read back with access code 3. A stray lookup therefore shows up as a page fault.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;

    localparam int REF_BIT   = 4;
    localparam int DIRTY_BIT = 5;
    localparam int CODE_LSB  = 0;

    localparam logic [7:0] SRC_SET = 8'h10;
    localparam logic [7:0] DST_SET = 8'hB0;

    typedef enum logic {
        ACC_SRC = 1'b0,
        ACC_DST = 1'b1
    } acc_e;

    typedef enum logic {
        STEP_UP   = 1'b0,
        STEP_DOWN = 1'b1
    } step_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_WPROT = 2'd1,
        FLT_PAGE  = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_EVAL,
        ST_WRITE,
        ST_RELOOK,
        ST_REEVAL,
        ST_DONE
    } st_e;

    typedef struct packed {
        acc_e  mode;
        step_e dir;
        logic  adv;
    } cmd_t;

    // Fault decision from the access kind and the two-bit access code.
    function automatic fault_e code_fault(acc_e m, logic [1:0] code);
        fault_e f;
        f = FLT_NONE;
        if (code == 2'd3)
            f = FLT_PAGE;
        else if (m == ACC_DST && code == 2'd2)
            f = FLT_WPROT;
        return f;
    endfunction

endpackage

// File: rtl/pmt_stepper.sv
module pmt_stepper
    import page_xlate_pkg::*;
#(
    parameter int HI_W  = 8,
    parameter int LO_W  = 16,
    parameter int OFS_W = 8
) (
    input  step_e             dir,
    input  logic [HI_W-1:0]   in_hi,
    input  logic [LO_W-1:0]   in_lo,
    output logic [HI_W-1:0]   out_hi,
    output logic [LO_W-1:0]   out_lo
);
    localparam logic [LO_W:0] PAGE_STEP = {{(LO_W-OFS_W){1'b0}}, 1'b1, {OFS_W{1'b0}}};
    localparam logic [HI_W-1:0] HI_ONE  = {{(HI_W-1){1'b0}}, 1'b1};

    logic [LO_W:0] up_sum;
    logic [LO_W:0] dn_diff;

    assign up_sum  = {1'b0, in_lo} + PAGE_STEP;
    assign dn_diff = {1'b0, in_lo} - PAGE_STEP;

    always_comb begin
        if (dir == STEP_UP) begin
            out_lo = up_sum[LO_W-1:0];
            out_hi = up_sum[LO_W] ? in_hi + HI_ONE : in_hi;
        end else begin
            out_lo = dn_diff[LO_W-1:0];
            out_hi = dn_diff[LO_W] ? in_hi - HI_ONE : in_hi;
        end
    end
endmodule

// File: rtl/pmt_judge.sv
module pmt_judge
    import page_xlate_pkg::*;
#(
    parameter int ENT_W = 16
) (
    input  acc_e             mode,
    input  logic [ENT_W-1:0] entry,
    output fault_e           fault,
    output logic             need_wr,
    output logic [ENT_W-1:0] new_entry
);
    logic [7:0] set_bits;
    logic       flag_ok;

    always_comb begin
        fault = code_fault(mode, entry[CODE_LSB +: 2]);
        if (mode == ACC_SRC) begin
            set_bits = SRC_SET;
            flag_ok  = entry[REF_BIT];
        end else begin
            set_bits = DST_SET;
            flag_ok  = entry[DIRTY_BIT];
        end
        need_wr   = (fault == FLT_NONE) && !flag_ok;
        new_entry = entry | {{(ENT_W-8){1'b0}}, set_bits};
    end
endmodule

// File: rtl/pmt_ctrl.sv
module pmt_ctrl
    import page_xlate_pkg::*;
#(
    parameter int HI_W  = 8,
    parameter int LO_W  = 16,
    parameter int OFS_W = 8,
    parameter int ENT_W = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cmd_valid,
    input  acc_e                          cmd_mode,
    input  logic                          cmd_adv,
    input  logic [HI_W-1:0]               cmd_hi,
    input  logic [LO_W-1:0]               cmd_lo,
    input  logic [HI_W-1:0]               step_hi,
    input  logic [LO_W-1:0]               step_lo,
    input  fault_e                        j_fault,
    input  logic                          j_wr,
    input  logic [ENT_W-1:0]              j_wdata,
    input  logic [ENT_W-1:0]              map_rdata,
    output acc_e                          mode_q,
    output logic                          accept,
    output logic [HI_W-1:0]               cur_hi,
    output logic [LO_W-1:0]               cur_lo,
    output logic                          busy,
    output logic                          map_rd_en,
    output logic                          map_wr_en,
    output logic [HI_W+LO_W-OFS_W-1:0]    map_addr,
    output logic [ENT_W-1:0]              map_wdata,
    output logic                          res_valid,
    output fault_e                        res_fault,
    output logic [ENT_W-1:0]              res_addr
);
    localparam int PG_W = ENT_W - OFS_W;

    st_e               st_q;
    logic [PG_W-1:0]   page_q;
    fault_e            fault_q;
    logic [ENT_W-1:0]  wdata_q;

    assign accept = (st_q == ST_IDLE) && cmd_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            mode_q  <= ACC_SRC;
            cur_hi  <= '0;
            cur_lo  <= '0;
            page_q  <= '0;
            fault_q <= FLT_NONE;
            wdata_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        mode_q <= cmd_mode;
                        if (cmd_adv) begin
                            cur_hi <= step_hi;
                            cur_lo <= step_lo;
                        end else begin
                            cur_hi <= cmd_hi;
                            cur_lo <= cmd_lo;
                        end
                        st_q <= ST_LOOK;
                    end
                end
                ST_LOOK:   st_q <= ST_EVAL;
                ST_EVAL: begin
                    page_q  <= map_rdata[ENT_W-1:OFS_W];
                    fault_q <= j_fault;
                    wdata_q <= j_wdata;
                    if (j_fault == FLT_NONE && j_wr)
                        st_q <= ST_WRITE;
                    else
                        st_q <= ST_DONE;
                end
                ST_WRITE:  st_q <= ST_RELOOK;
                ST_RELOOK: st_q <= ST_REEVAL;
                ST_REEVAL: begin
                    page_q <= map_rdata[ENT_W-1:OFS_W];
                    st_q   <= ST_DONE;
                end
                ST_DONE:   st_q <= ST_IDLE;
                default:   st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (st_q != ST_IDLE);
    assign map_rd_en = (st_q == ST_LOOK) || (st_q == ST_RELOOK);
    assign map_wr_en = (st_q == ST_WRITE);
    assign map_addr  = {cur_hi, cur_lo[LO_W-1:OFS_W]};
    assign map_wdata = wdata_q;
    assign res_valid = (st_q == ST_DONE);
    assign res_fault = fault_q;
    assign res_addr  = (fault_q == FLT_NONE) ? {page_q, cur_lo[OFS_W-1:0]} : '0;

    AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !busy && !res_valid); // R11

    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_fault != FLT_NONE) |-> (res_addr == '0)); // R2

    AST_REREAD_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        map_wr_en |=> (!map_wr_en && $stable(map_addr))); // R7

    AST_WPROT_ONLY_DST: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_fault == FLT_WPROT) |-> (mode_q == ACC_DST)); // R5

    AST_SRC_SETS_REF: assert property (@(posedge clk) disable iff (rst)
        (map_wr_en && mode_q == ACC_SRC) |-> map_wdata[REF_BIT]); // R4

    AST_DST_SETS_DIRTY: assert property (@(posedge clk) disable iff (rst)
        (map_wr_en && mode_q == ACC_DST) |-> (map_wdata[7] && map_wdata[DIRTY_BIT] && map_wdata[REF_BIT])); // R6
endmodule

// File: rtl/page_xlate.sv
module page_xlate
    import page_xlate_pkg::*;
#(
    parameter int HI_W  = 8,
    parameter int LO_W  = 16,
    parameter int OFS_W = 8,
    parameter int ENT_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cmd_valid,
    input  logic                       cmd_mode,
    input  logic                       cmd_dir,
    input  logic                       cmd_adv,
    input  logic [HI_W-1:0]            cmd_va_hi,
    input  logic [LO_W-1:0]            cmd_va_lo,
    output logic                       busy,
    output logic                       map_rd_en,
    output logic                       map_wr_en,
    output logic [HI_W+LO_W-OFS_W-1:0] map_addr,
    output logic [ENT_W-1:0]           map_wdata,
    input  logic [ENT_W-1:0]           map_rdata,
    output logic                       res_valid,
    output logic [1:0]                 res_fault,
    output logic [ENT_W-1:0]           res_addr,
    output logic [HI_W-1:0]            cur_va_hi,
    output logic [LO_W-1:0]            cur_va_lo
);
    localparam logic [HI_W+LO_W-1:0] VA_PAGE = {{(HI_W+LO_W-OFS_W-1){1'b0}}, 1'b1, {OFS_W{1'b0}}};

    cmd_t              cmd;
    acc_e              mode_q;
    logic              accept;
    logic [HI_W-1:0]   step_hi;
    logic [LO_W-1:0]   step_lo;
    fault_e            j_fault;
    logic              j_wr;
    logic [ENT_W-1:0]  j_wdata;
    fault_e            fault_w;

    assign cmd.mode = acc_e'(cmd_mode);
    assign cmd.dir  = step_e'(cmd_dir);
    assign cmd.adv  = cmd_adv;

    pmt_stepper #(.HI_W(HI_W), .LO_W(LO_W), .OFS_W(OFS_W)) u_step (
        .dir    (cmd.dir),
        .in_hi  (cur_va_hi),
        .in_lo  (cur_va_lo),
        .out_hi (step_hi),
        .out_lo (step_lo)
    );

    pmt_judge #(.ENT_W(ENT_W)) u_judge (
        .mode      (mode_q),
        .entry     (map_rdata),
        .fault     (j_fault),
        .need_wr   (j_wr),
        .new_entry (j_wdata)
    );

    pmt_ctrl #(.HI_W(HI_W), .LO_W(LO_W), .OFS_W(OFS_W), .ENT_W(ENT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_mode  (cmd.mode),
        .cmd_adv   (cmd.adv),
        .cmd_hi    (cmd_va_hi),
        .cmd_lo    (cmd_va_lo),
        .step_hi   (step_hi),
        .step_lo   (step_lo),
        .j_fault   (j_fault),
        .j_wr      (j_wr),
        .j_wdata   (j_wdata),
        .map_rdata (map_rdata),
        .mode_q    (mode_q),
        .accept    (accept),
        .cur_hi    (cur_va_hi),
        .cur_lo    (cur_va_lo),
        .busy      (busy),
        .map_rd_en (map_rd_en),
        .map_wr_en (map_wr_en),
        .map_addr  (map_addr),
        .map_wdata (map_wdata),
        .res_valid (res_valid),
        .res_fault (fault_w),
        .res_addr  (res_addr)
    );

    assign res_fault = fault_w;

    AST_FWD_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(accept && cmd.adv && cmd.dir == STEP_UP))
        |-> ({cur_va_hi, cur_va_lo} == $past({cur_va_hi, cur_va_lo}) + VA_PAGE)); // R8

    AST_BACK_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(accept && cmd.adv && cmd.dir == STEP_DOWN))
        |-> ({cur_va_hi, cur_va_lo} == $past({cur_va_hi, cur_va_lo}) - VA_PAGE)); // R9

    AST_LOAD_CMD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(accept && !cmd.adv))
        |-> ({cur_va_hi, cur_va_lo} == $past({cmd_va_hi, cmd_va_lo}))); // R10
endmodule

// File: tb/sim_page_xlate.sv
`timescale 1ns/1ps
module sim_page_xlate;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid, cmd_mode, cmd_dir, cmd_adv;
    logic [7:0]  cmd_va_hi;
    logic [15:0] cmd_va_lo;
    logic        busy, map_rd_en, map_wr_en, res_valid;
    logic [15:0] map_addr, map_wdata, map_rdata, res_addr, cur_va_lo;
    logic [1:0]  res_fault;
    logic [7:0]  cur_va_hi;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] mem [logic [15:0]];
    int          n_rd, n_wr;
    logic [15:0] last_rd_addr, last_wr_addr, last_wr_data;

    int          lat;
    logic [1:0]  got_fault;
    logic [15:0] got_addr;

    always #4 clk = ~clk;

    page_xlate u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
        .cmd_dir(cmd_dir), .cmd_adv(cmd_adv), .cmd_va_hi(cmd_va_hi),
        .cmd_va_lo(cmd_va_lo), .busy(busy), .map_rd_en(map_rd_en),
        .map_wr_en(map_wr_en), .map_addr(map_addr), .map_wdata(map_wdata),
        .map_rdata(map_rdata), .res_valid(res_valid), .res_fault(res_fault),
        .res_addr(res_addr), .cur_va_hi(cur_va_hi), .cur_va_lo(cur_va_lo)
    );

    // Map memory: one-cycle read latency; unfilled indices read as access code 3.
    always @(posedge clk) begin
        if (map_rd_en) begin
            map_rdata <= mem.exists(map_addr) ? mem[map_addr] : 16'h0003;
            n_rd = n_rd + 1;
            last_rd_addr = map_addr;
        end
        if (map_wr_en) begin
            mem[map_addr] = map_wdata;
            n_wr = n_wr + 1;
            last_wr_addr = map_addr;
            last_wr_data = map_wdata;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input logic mode, input logic dir, input logic adv,
                       input logic [7:0] hi, input logic [15:0] lo);
        @(negedge clk);
        n_rd = 0; n_wr = 0;
        cmd_valid = 1'b1; cmd_mode = mode; cmd_dir = dir; cmd_adv = adv;
        cmd_va_hi = hi; cmd_va_lo = lo;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_va_hi = 8'hEE; cmd_va_lo = 16'hEEEE;
        lat = 1;
        chk("R11 busy after accept", {31'd0, busy}, 32'd1);
        while (!res_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        got_fault = res_fault;
        got_addr  = res_addr;
        @(negedge clk);
        chk("R11 busy drops after result", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R11 reset busy", {31'd0, busy}, 32'd0);
        chk("R11 reset res_valid", {31'd0, res_valid}, 32'd0);
        chk("R11 reset strobes", {30'd0, map_rd_en, map_wr_en}, 32'd0);
    endtask

    task automatic t_src_hit();
        mem[16'h1234] = 16'h7710;
        run(1'b0, 1'b0, 1'b0, 8'h12, 16'h3456);
        chk("R1 index", last_rd_addr, 16'h1234);
        chk("R2 real addr", got_addr, 16'h7756);
        chk("R2 no fault", got_fault, 2'd0);
        chk("R4 referenced: no write", n_wr, 0);
        chk("R11 latency short", lat, 3);
        chk("R10 current va", {cur_va_hi, cur_va_lo}, 24'h123456);
    endtask

    task automatic t_src_fill();
        mem[16'h2001] = 16'h5602;
        run(1'b0, 1'b0, 1'b0, 8'h20, 16'h01C3);
        chk("R3 code 2 src no fault", got_fault, 2'd0);
        chk("R4 one write", n_wr, 1);
        chk("R4 write data", last_wr_data, 16'h5612);
        chk("R1 write index", last_wr_addr, 16'h2001);
        chk("R7 two reads", n_rd, 2);
        chk("R7 page from reread", got_addr, 16'h56C3);
        chk("R11 latency long", lat, 6);
    endtask

    task automatic t_src_fault();
        mem[16'h2100] = 16'hAB13;
        run(1'b0, 1'b0, 1'b0, 8'h21, 16'h0077);
        chk("R3 page fault", got_fault, 2'd2);
        chk("R3 no write", n_wr, 0);
        chk("R2 fault addr zero", got_addr, 16'h0000);
    endtask

    task automatic t_dst_faults();
        mem[16'h3000] = 16'h6622;
        run(1'b1, 1'b0, 1'b0, 8'h30, 16'h0011);
        chk("R5 write-protect", got_fault, 2'd1);
        chk("R5 no write wp", n_wr, 0);
        chk("R2 wp addr zero", got_addr, 16'h0000);
        mem[16'h3001] = 16'h66B3;
        run(1'b1, 1'b0, 1'b0, 8'h30, 16'h0122);
        chk("R5 dst page fault", got_fault, 2'd2);
        chk("R5 no write pf", n_wr, 0);
    endtask

    task automatic t_dst_update();
        mem[16'h3100] = 16'h7811;
        run(1'b1, 1'b0, 1'b0, 8'h31, 16'h00A5);
        chk("R6 no fault", got_fault, 2'd0);
        chk("R6 write data", last_wr_data, 16'h78B1);
        chk("R6 result", got_addr, 16'h78A5);
        chk("R7 stored entry", mem[16'h3100], 16'h78B1);
        mem[16'h3200] = 16'h9A20;
        run(1'b1, 1'b0, 1'b0, 8'h32, 16'h003C);
        chk("R6 dirty: no write", n_wr, 0);
        chk("R6 dirty result", got_addr, 16'h9A3C);
        chk("R11 dirty latency", lat, 3);
    endtask

    task automatic t_adv_fwd();
        mem[16'h40FF] = 16'h1110;
        mem[16'h4100] = 16'h2210;
        mem[16'h4101] = 16'h2310;
        run(1'b0, 1'b0, 1'b0, 8'h40, 16'hFF2C);
        chk("R2 base page", got_addr, 16'h112C);
        run(1'b0, 1'b0, 1'b1, 8'h99, 16'h1111);
        chk("R8 carry into hi", {cur_va_hi, cur_va_lo}, 24'h41002C);
        chk("R8 index after step", last_rd_addr, 16'h4100);
        chk("R8 offset merged", got_addr, 16'h222C);
        run(1'b0, 1'b0, 1'b1, 8'h00, 16'h0000);
        chk("R8 plain step", {cur_va_hi, cur_va_lo}, 24'h41012C);
        chk("R8 plain result", got_addr, 16'h232C);
    endtask

    task automatic t_adv_back();
        run(1'b0, 1'b1, 1'b1, 8'h55, 16'h5555);
        chk("R9 plain step back", {cur_va_hi, cur_va_lo}, 24'h41002C);
        chk("R9 result", got_addr, 16'h222C);
        run(1'b0, 1'b1, 1'b1, 8'h55, 16'h5555);
        chk("R9 borrow from hi", {cur_va_hi, cur_va_lo}, 24'h40FF2C);
        chk("R9 index after borrow", last_rd_addr, 16'h40FF);
        chk("R9 borrow result", got_addr, 16'h112C);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        rst = 1'b1;
        cmd_valid = 1'b0; cmd_mode = 1'b0; cmd_dir = 1'b0; cmd_adv = 1'b0;
        cmd_va_hi = '0; cmd_va_lo = '0;
        n_rd = 0; n_wr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_src_hit();
        t_src_fill();
        t_src_fault();
        t_dst_faults();
        t_dst_update();
        t_adv_fwd();
        t_adv_back();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule